// File: doc/BRIEF.md
# PCI Initiator Bus Acquisition Controller

This block sits in front of the transaction engine of a 32-bit PCI initiator and decides the clock on which the device may begin driving the shared bus. When the engine raises its bus-want input, the block drives the active-low request line toward the arbiter. It then watches the active-low grant together with the frame and initiator-ready lines. Holding the grant is not enough: the previous owner may still be finishing a transfer. The block therefore issues its start strobe only on a clock where the grant is held and both frame and initiator-ready are high, which is the idle bus.

Every PCI line is active-low and sampled on the rising clock edge. A grant that is withdrawn while the bus is still busy sends the block back to requesting without any start. The decoded bus phase is registered and brought out for debug. The number of clocks spent between the grant and the start is measured and presented on a latency output, which saturates at its full-scale value.

Top module: `pci_acq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `req_n` reads 1, `start_o` 0, `phase_o` 2'b00 and `lat_o` 0.
- R2: A high `want_bus` sampled at an edge in the quiet state drives `req_n` low after that edge. `req_n` stays low until a start is issued or `want_bus` is sampled low.
- R3: `phase_o` shows, one edge late, the pair sampled at the previous edge encoded as {~frame_n, ~irdy_n}: 00 idle, 01 final data phase of another master, 10 transfer stalled, 11 data moving.
- R4: `start_o` is high for exactly one cycle. It rises after an edge at which the block was requesting and sampled `gnt_n`=0, `frame_n`=1 and `irdy_n`=1, and never otherwise.
- R5: A sampled pair with frame high and initiator-ready low (final data phase) never produces a start, even with the grant held.
- R6: A stalled transfer (frame low, initiator-ready high) or an active transfer (both low) never produces a start while it lasts.
- R7: If `gnt_n` is sampled high while the block waits for idle, no start is issued and `req_n` stays low. The latency measurement begins again at the next grant.
- R8: `lat_o` changes only together with `start_o`. It then holds the number of edges from the first edge that sampled the grant to the start edge, which is 0 when the bus was already idle.
- R9: The latency value saturates at 2^LAT_W-1 (255 by default) and does not wrap.
- R10: After a start, `req_n` reads 1 and no further start is issued until `want_bus` has been sampled low and then high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| want_bus | input | 1 | Transaction engine asks for bus ownership |
| gnt_n | input | 1 | Arbiter grant, active low |
| frame_n | input | 1 | Bus frame line, active low |
| irdy_n | input | 1 | Bus initiator-ready line, active low |
| req_n | output | 1 | Request to arbiter, active low, registered |
| start_o | output | 1 | One-cycle permission for the engine to drive the bus |
| phase_o | output | 2 | Registered decoded bus phase |
| lat_o | output | LAT_W | Grant-to-start latency of the last acquisition |

## Verification
Acquisitions are run with the bus already idle and behind each of the three busy phases for different lengths. This separates the final-data phase, the stalled phase and the active phase, since each must hold the start back and each yields a distinct expected latency. A grant that disappears mid-wait and then returns over an idle bus shows that the measurement restarts and that an idle bus without a grant starts nothing. A 300-clock busy stretch exposes the saturation, and holding the bus-want high after a start shows that no second start follows.

// File: rtl/pci_acq_pkg.sv
package pci_acq_pkg;

  typedef enum logic [1:0] {
    ST_QUIET = 2'd0,
    ST_ASK   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_OWNED = 2'd3
  } acq_state_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_LAST  = 2'b01,
    PH_STALL = 2'b10,
    PH_XFER  = 2'b11
  } bus_phase_t;

endpackage

// File: rtl/pci_acq_phase.sv
module pci_acq_phase
  import pci_acq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_n,
  input  logic       irdy_n,
  output logic       idle_now,
  output bus_phase_t phase_q
);

  bus_phase_t phase_now;

  always_comb begin
    unique case ({frame_n, irdy_n})
      2'b11:   phase_now = PH_IDLE;
      2'b10:   phase_now = PH_LAST;
      2'b01:   phase_now = PH_STALL;
      default: phase_now = PH_XFER;
    endcase
  end

  assign idle_now = (phase_now == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_now;
  end

endmodule

// File: rtl/pci_acq_fsm.sv
module pci_acq_fsm
  import pci_acq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic want_bus,
  input  logic gnt_n,
  input  logic idle_now,
  output logic req_n_q,
  output logic start_q,
  output logic enter_hold,
  output logic stay_hold,
  output logic fire,
  output logic in_hold
);

  acq_state_t state, state_nx;

  always_comb begin
    state_nx   = state;
    enter_hold = 1'b0;
    stay_hold  = 1'b0;
    fire       = 1'b0;
    unique case (state)
      ST_QUIET: if (want_bus) state_nx = ST_ASK;
      ST_ASK: begin
        if (!want_bus) state_nx = ST_QUIET;
        else if (!gnt_n && idle_now) begin
          fire     = 1'b1;
          state_nx = ST_OWNED;
        end else if (!gnt_n) begin
          enter_hold = 1'b1;
          state_nx   = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!want_bus) state_nx = ST_QUIET;
        else if (gnt_n) state_nx = ST_ASK;
        else if (idle_now) begin
          fire     = 1'b1;
          state_nx = ST_OWNED;
        end else stay_hold = 1'b1;
      end
      default: if (!want_bus) state_nx = ST_QUIET;
    endcase
  end

  assign in_hold = (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_QUIET;
      req_n_q <= 1'b1;
      start_q <= 1'b0;
    end else begin
      state   <= state_nx;
      req_n_q <= !(state_nx == ST_ASK || state_nx == ST_HOLD);
      start_q <= fire;
    end
  end

endmodule

// File: rtl/pci_acq_lat.sv
module pci_acq_lat #(
  parameter int LAT_W    = 8,
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter_hold,
  input  logic             stay_hold,
  input  logic             fire,
  input  logic             in_hold,
  output logic [LAT_W-1:0] lat_q
);

  localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};
  localparam logic [LAT_W-1:0] LAT_ONE = {{(LAT_W-1){1'b0}}, 1'b1};

  logic [LAT_W-1:0] cnt, cnt_inc;

  generate
    if (SATURATE) begin : g_sat
      assign cnt_inc = (cnt == LAT_MAX) ? LAT_MAX : cnt + LAT_ONE;
    end else begin : g_wrap
      assign cnt_inc = cnt + LAT_ONE;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      lat_q <= '0;
    end else begin
      if (enter_hold)     cnt <= LAT_ONE;
      else if (stay_hold) cnt <= cnt_inc;
      else                cnt <= '0;
      if (fire) lat_q <= in_hold ? cnt : '0;
    end
  end

endmodule

// File: rtl/pci_acq_ctrl.sv
module pci_acq_ctrl
  import pci_acq_pkg::*;
#(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             want_bus,
  input  logic             gnt_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  output logic             req_n,
  output logic             start_o,
  output logic [1:0]       phase_o,
  output logic [LAT_W-1:0] lat_o
);

  logic       idle_now, enter_hold, stay_hold, fire, in_hold;
  bus_phase_t phase_q;

  pci_acq_phase u_phase (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
    .idle_now(idle_now), .phase_q(phase_q)
  );

  pci_acq_fsm u_fsm (
    .clk(clk), .rst(rst), .want_bus(want_bus), .gnt_n(gnt_n),
    .idle_now(idle_now), .req_n_q(req_n), .start_q(start_o),
    .enter_hold(enter_hold), .stay_hold(stay_hold), .fire(fire),
    .in_hold(in_hold)
  );

  pci_acq_lat #(.LAT_W(LAT_W), .SATURATE(1'b1)) u_lat (
    .clk(clk), .rst(rst), .enter_hold(enter_hold), .stay_hold(stay_hold),
    .fire(fire), .in_hold(in_hold), .lat_q(lat_o)
  );

  assign phase_o = phase_q;

endmodule

// File: rtl/pci_acq_ctrl_chk.sv
module pci_acq_ctrl_chk #(
  parameter int LAT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             want_bus,
  input logic             gnt_n,
  input logic             frame_n,
  input logic             irdy_n,
  input logic             req_n,
  input logic             start_o,
  input logic [1:0]       phase_o,
  input logic [LAT_W-1:0] lat_o
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (req_n && !start_o && phase_o == 2'b00 && lat_o == '0));

  assert_phase_track_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phase_o == {~$past(frame_n), ~$past(irdy_n)});

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  assert_start_needs_idle_grant_R4: assert property (@(posedge clk) disable iff (rst)
    start_o |-> ($past(!gnt_n) && $past(frame_n) && $past(irdy_n) && !$past(req_n)));

  assert_lat_moves_with_start_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !start_o) |-> $stable(lat_o));

  assert_request_released_R10: assert property (@(posedge clk) disable iff (rst)
    start_o |-> req_n);

endmodule

bind pci_acq_ctrl pci_acq_ctrl_chk #(.LAT_W(LAT_W)) u_chk (
  .clk(clk), .rst(rst), .want_bus(want_bus), .gnt_n(gnt_n),
  .frame_n(frame_n), .irdy_n(irdy_n), .req_n(req_n), .start_o(start_o),
  .phase_o(phase_o), .lat_o(lat_o)
);

// File: tb/pci_acq_ctrl_test.sv
`timescale 1ns/1ps
module pci_acq_ctrl_test;

  localparam int LAT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             want_bus = 1'b0;
  logic             gnt_n = 1'b1;
  logic             frame_n = 1'b1;
  logic             irdy_n = 1'b1;
  logic             req_n, start_o;
  logic [1:0]       phase_o;
  logic [LAT_W-1:0] lat_o;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  pci_acq_ctrl #(.LAT_W(LAT_W)) uut (
    .clk(clk), .rst(rst), .want_bus(want_bus), .gnt_n(gnt_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .req_n(req_n), .start_o(start_o),
    .phase_o(phase_o), .lat_o(lat_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every start pulse pops one expected latency
  always @(negedge clk) begin
    if (!rst && start_o) begin
      if (exp_q.size() == 0) chk("R4 unexpected start", 1, 0);
      else chk("R8 latency", int'(lat_o), exp_q.pop_front());
    end
  end

  task automatic acquire(input int n, input logic [1:0] ph);
    @(negedge clk);
    want_bus = 1'b1; gnt_n = 1'b1; frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    chk("R2 req asserted", req_n, 0);
    exp_q.push_back((n > 255) ? 255 : n);
    gnt_n = 1'b0;
    if (n > 0) begin frame_n = ~ph[1]; irdy_n = ~ph[0]; end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i < 3) begin
        chk(ph == 2'b01 ? "R5 no start in last phase" : "R6 no start while busy",
            start_o, 0);
        chk("R3 phase", phase_o, ph);
      end
    end
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R4 single pulse", start_o, 0);
    chk("R10 req released", req_n, 1);
    want_bus = 1'b0; gnt_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req_n", req_n, 1);
    chk("R1 start", start_o, 0);
    chk("R1 phase", phase_o, 0);
    chk("R1 lat", lat_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 no req without want", req_n, 1);

    acquire(0, 2'b00);
    acquire(3, 2'b11);
    acquire(2, 2'b01);
    acquire(4, 2'b10);

    // R7: grant withdrawn while busy, then returned over idle bus
    @(negedge clk);
    want_bus = 1'b1;
    @(negedge clk);
    gnt_n = 1'b0; frame_n = 1'b0; irdy_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 no start while waiting", start_o, 0);
    gnt_n = 1'b1;
    @(negedge clk);
    chk("R7 req kept", req_n, 0);
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    chk("R4 no start without grant", start_o, 0);
    chk("R7 still requesting", req_n, 0);
    chk("R8 lat held", lat_o, 4);
    exp_q.push_back(0);
    gnt_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R10: keep want high, grant and idle; no second start
    repeat (3) begin
      @(negedge clk);
      chk("R10 no restart", start_o, 0);
      chk("R10 req high", req_n, 1);
    end
    want_bus = 1'b0; gnt_n = 1'b1;
    @(negedge clk);

    // R9: saturation
    acquire(300, 2'b11);
    chk("R9 saturated value held", lat_o, 255);

    chk("R8 all starts seen", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        chk("watchdog expired", 1, 0);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule